// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Break Handling

This block is a full-duplex asynchronous serial port with a byte-wide parallel side. A single transmit line and a single receive line run independently. The transmit path has a holding register in front of a shifter. The receive path has a shifter in front of a receive buffer. Software-side logic can therefore write the next character while the current one is still going out, and can read one character while the next is arriving.

Live configuration inputs select the frame: 5 to 8 data bits, optional even or odd parity, and 1, 1.5 or 2 stop bits on transmit. They also select how many serial-clock ticks make one bit time. The serial clock is a one-cycle enable `sclk_en` on the system clock, so a baud-rate divider upstream sets the line rate.

The transmitter can hold its line low on command to send a break. The receiver rejects start edges that do not survive to mid-bit and recognises an all-low frame as a break. It keeps sticky parity, overrun and framing flags until they are cleared. The configuration inputs must be held stable while either direction is mid-character.

Top module: `async_usart`

## Requirements
- R1: `char_len` selects 5 + `char_len` data bits (0 gives 5, 3 gives 8). Data is sent and received least significant bit first. A received character appears right-aligned in `rx_data`, with the unused upper bits zero.
- R2: `clk_mult` selects the ticks per bit time: 0 gives 1, 1 gives 16, and 2 or 3 give 64. A tick is a clock cycle with `sclk_en` high. Every transmitted bit lasts exactly that many ticks, and clock cycles without a tick advance nothing.
- R3: `stop_sel` sets the transmit stop time in ticks, with M the ticks per bit. A value of 0 gives M, 1 gives M + floor(M/2), and 2 or 3 give 2M. When the holding register is full at the end of the stop time, the next start bit begins on that same tick.
- R4: When `parity_en` is high, one parity bit follows the data bits. With `parity_odd` low, the data bits and the parity bit together hold an even number of ones; with it high, an odd number. A received parity bit that breaks this rule sets `parity_err`.
- R5: While `send_break` is high, `txd` is low regardless of what the transmitter is doing.
- R6: In ×16 and ×64 modes, a low level seen on the idle receive line is re-sampled M/2 ticks later. If the line is then high, the edge is discarded, no character is delivered, and the receiver hunts again.
- R7: A received frame whose sampled data, parity and stop bits are all low sets `break_det`. The character is still delivered, as zero with a framing error. `break_det` stays high until the receive line is seen high on a tick, and no new start is hunted before then.
- R8: A stop bit sampled low sets `framing_err`.
- R9: A character that completes while `rx_ready` is high, with no `rx_read` in that cycle, sets `overrun_err`. The new character replaces the old one in `rx_data`.
- R10: `tx_ready` is high when the holding register is empty. A `tx_write` while it is low is ignored. `tx_empty` is high only when both the holding register and the shifter are empty.
- R11: `parity_err`, `overrun_err` and `framing_err` stay set until an `err_clr` pulse. `rx_read` clears `rx_ready`.
- R12: After reset, `txd` is high, `tx_ready` and `tx_empty` are high, and `rx_ready` and all four status flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_en | input | 1 | Serial clock tick enable |
| char_len | input | 2 | Data bits minus five |
| parity_en | input | 1 | Parity bit present |
| parity_odd | input | 1 | Odd (1) or even (0) parity |
| stop_sel | input | 2 | Transmit stop time select |
| clk_mult | input | 2 | Ticks per bit select |
| send_break | input | 1 | Force transmit line low |
| tx_data | input | 8 | Character to transmit |
| tx_write | input | 1 | Write `tx_data` to the holding register |
| tx_ready | output | 1 | Holding register empty |
| tx_empty | output | 1 | Holding register and shifter both empty |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rx_read | input | 1 | Acknowledge the buffered character |
| rx_data | output | 8 | Last received character |
| rx_ready | output | 1 | Unread character in the buffer |
| err_clr | input | 1 | Clear the sticky error flags |
| parity_err | output | 1 | Parity error seen |
| overrun_err | output | 1 | Overrun error seen |
| framing_err | output | 1 | Framing error seen |
| break_det | output | 1 | Break condition on the receive line |

## Verification
The bench attacks the following corner cases:
- **Transmit hand-off.** A write that lands while the holding register is still full must be dropped. A one-tick slip in the load after the stop time would show up as a shifted line against the tick-accurate model.
- **Stop time and gated serial clock.** The 1.5-stop length in ×16 and the gated serial clock would expose a stop counter that rounds differently, or logic that advances on every clock instead of on ticks.
- **Receive-side traps.** A short low glitch must not produce a character. The half-bit remnant after a low stop bit must not start a phantom frame. A long low line must raise the break flag and keep it until the line returns high, rather than re-triggering.
- **Overrun replacement.** Two unread characters must leave the second one in the buffer.

// File: rtl/usart_pkg.sv
package usart_pkg;

  localparam int DW = 8;   // widest character
  localparam int CW = 8;   // tick counters, up to two 64-tick bit times
  localparam int IW = 4;   // bit index within a frame

  typedef struct packed {
    logic [1:0] len;
    logic       par_en;
    logic       par_odd;
    logic [1:0] stop;
    logic [1:0] mult;
  } usart_cfg_t;

  function automatic logic [CW-1:0] bit_ticks(input logic [1:0] mult);
    case (mult)
      2'd0:    return CW'(1);
      2'd1:    return CW'(16);
      default: return CW'(64);
    endcase
  endfunction

  function automatic logic [CW-1:0] stop_ticks(input logic [1:0] mult, input logic [1:0] stop);
    logic [CW-1:0] m;
    m = bit_ticks(mult);
    case (stop)
      2'd0:    return m;
      2'd1:    return m + (m >> 1);
      default: return m << 1;
    endcase
  endfunction

  function automatic logic [IW-1:0] data_bits(input logic [1:0] len);
    return IW'(5) + IW'(len);
  endfunction

  function automatic logic [DW-1:0] len_mask(input logic [1:0] len);
    return DW'((9'd1 << data_bits(len)) - 9'd1);
  endfunction

  function automatic logic parity_of(input logic [DW-1:0] d, input logic [1:0] len,
                                     input logic odd);
    return (^(d & len_mask(len))) ^ odd;
  endfunction

  // bits that follow the start bit: data LSB first, optional parity, ones above
  function automatic logic [DW:0] tx_frame(input logic [DW-1:0] d, input logic [1:0] len,
                                           input logic par_en, input logic par_odd);
    logic [DW:0] f;
    f = '1;
    for (int i = 0; i < DW; i++)
      if (i < int'(data_bits(len))) f[i] = d[i];
    if (par_en) f[data_bits(len)] = parity_of(d, len, par_odd);
    return f;
  endfunction

  function automatic logic [DW-1:0] rx_align(input logic [DW-1:0] sh, input logic [1:0] len);
    return sh >> (IW'(DW) - data_bits(len));
  endfunction

endpackage

// File: rtl/usart_tx.sv
module usart_tx
  import usart_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  usart_cfg_t       cfg,
  input  logic             wr,
  input  logic [DW-1:0]    wr_data,
  input  logic             brk,
  output logic             txd,
  output logic             ready,
  output logic             empty,
  output logic             load_evt
);

  typedef enum logic [1:0] {TX_IDLE, TX_BITS, TX_STOP} tx_st_e;

  tx_st_e        st;
  logic [DW-1:0] thr;
  logic          thr_full;
  logic [DW:0]   sh;
  logic [IW-1:0] left;
  logic [CW-1:0] tcnt;
  logic          txq;
  logic [CW-1:0] m_ticks, s_ticks;
  logic          bit_end, stop_end;

  assign m_ticks  = bit_ticks(cfg.mult);
  assign s_ticks  = stop_ticks(cfg.mult, cfg.stop);
  assign bit_end  = tick && (st == TX_BITS) && (tcnt == m_ticks - 1'b1);
  assign stop_end = tick && (st == TX_STOP) && (tcnt == s_ticks - 1'b1);
  assign load_evt = thr_full && ((tick && (st == TX_IDLE)) || stop_end);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= TX_IDLE;
      thr      <= '0;
      thr_full <= 1'b0;
      sh       <= '1;
      left     <= '0;
      tcnt     <= '0;
      txq      <= 1'b1;
    end else begin
      if (wr && !thr_full) begin
        thr      <= wr_data;
        thr_full <= 1'b1;
      end else if (load_evt) begin
        thr_full <= 1'b0;
      end

      if (load_evt) begin
        st   <= TX_BITS;
        txq  <= 1'b0;
        sh   <= tx_frame(thr, cfg.len, cfg.par_en, cfg.par_odd);
        left <= data_bits(cfg.len) + IW'(cfg.par_en);
        tcnt <= '0;
      end else if (stop_end) begin
        st   <= TX_IDLE;
        tcnt <= '0;
      end else if (bit_end) begin
        tcnt <= '0;
        if (left == '0) begin
          st  <= TX_STOP;
          txq <= 1'b1;
        end else begin
          txq  <= sh[0];
          sh   <= {1'b1, sh[DW:1]};
          left <= left - 1'b1;
        end
      end else if (tick && (st != TX_IDLE)) begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  assign ready = !thr_full;
  assign empty = !thr_full && (st == TX_IDLE);
  assign txd   = brk ? 1'b0 : txq;

  // R10
  empty_implies_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> ready);

  // R10
  write_while_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !ready) |=> $stable(thr));

  // R2
  bit_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TX_BITS) |-> (tcnt < m_ticks));

endmodule

// File: rtl/usart_rx.sv
module usart_rx
  import usart_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [1:0]       len,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic [1:0]       mult,
  input  logic             rxd_in,
  output logic             done,
  output logic [DW-1:0]    d_out,
  output logic             perr,
  output logic             ferr,
  output logic             brk_evt,
  output logic             brk_end,
  output logic             false_evt
);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_BRK} rx_st_e;

  rx_st_e        st;
  logic [1:0]    sy;
  logic          rx;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sh;
  logic [IW-1:0] idx;
  logic          any_high;
  logic          par_rx;
  logic [CW-1:0] m_ticks;
  logic [IW-1:0] n_bits;
  logic          sample, is_stop;

  assign rx      = sy[1];
  assign m_ticks = bit_ticks(mult);
  assign n_bits  = data_bits(len);
  assign sample  = tick && (st == RX_BITS) && (cnt == m_ticks - 1'b1);
  assign is_stop = (idx == n_bits + IW'(par_en));

  assign done      = sample && is_stop;
  assign d_out     = rx_align(sh, len);
  assign perr      = par_en && (par_rx != parity_of(d_out, len, par_odd));
  assign ferr      = !rx;
  assign brk_evt   = done && !rx && !any_high;
  assign brk_end   = tick && (st == RX_BRK) && rx;
  assign false_evt = tick && (st == RX_START) && (cnt == (m_ticks >> 1)) && rx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sy <= 2'b11;
    end else begin
      sy <= {sy[0], rxd_in};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= RX_IDLE;
      cnt      <= '0;
      sh       <= '0;
      idx      <= '0;
      any_high <= 1'b0;
      par_rx   <= 1'b0;
    end else begin
      case (st)
        RX_IDLE: begin
          if (tick && !rx) begin
            idx      <= '0;
            any_high <= 1'b0;
            if (m_ticks == CW'(1)) begin
              st  <= RX_BITS;
              cnt <= '0;
            end else begin
              st  <= RX_START;
              cnt <= CW'(1);
            end
          end
        end
        RX_START: begin
          if (tick) begin
            if (cnt == (m_ticks >> 1)) begin
              cnt <= '0;
              st  <= rx ? RX_IDLE : RX_BITS;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        RX_BITS: begin
          if (tick) begin
            if (cnt == m_ticks - 1'b1) begin
              cnt      <= '0;
              idx      <= idx + 1'b1;
              any_high <= any_high | rx;
              if (idx < n_bits)  sh     <= {rx, sh[DW-1:1]};
              else if (!is_stop) par_rx <= rx;
              if (is_stop) st <= brk_evt ? RX_BRK : RX_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: begin
          if (brk_end) st <= RX_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/usart_rxbuf.sv
module usart_rxbuf
  import usart_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done,
  input  logic [DW-1:0] d_in,
  input  logic          perr,
  input  logic          ferr,
  input  logic          brk_evt,
  input  logic          brk_end,
  input  logic          rd,
  input  logic          clr,
  output logic [DW-1:0] data,
  output logic          ready,
  output logic          perr_f,
  output logic          ovr_f,
  output logic          ferr_f,
  output logic          brk_f
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data   <= '0;
      ready  <= 1'b0;
      perr_f <= 1'b0;
      ovr_f  <= 1'b0;
      ferr_f <= 1'b0;
      brk_f  <= 1'b0;
    end else begin
      if (done) data <= d_in;
      ready  <= done | (ready & ~rd);
      ovr_f  <= (ovr_f & ~clr) | (done & ready & ~rd);
      perr_f <= (perr_f & ~clr) | (done & perr);
      ferr_f <= (ferr_f & ~clr) | (done & ferr);
      brk_f  <= brk_evt | (brk_f & ~brk_end);
    end
  end

  // R9
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ready && !rd) |=> ovr_f);

  // R8
  framing_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ferr) |=> ferr_f);

  // R7
  break_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> brk_f);

  // R11
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_f && !clr) |=> ovr_f);

endmodule

// File: rtl/async_usart.sv
module async_usart
  import usart_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_en,
  input  logic [1:0]    char_len,
  input  logic          parity_en,
  input  logic          parity_odd,
  input  logic [1:0]    stop_sel,
  input  logic [1:0]    clk_mult,
  input  logic          send_break,
  input  logic [7:0]    tx_data,
  input  logic          tx_write,
  output logic          tx_ready,
  output logic          tx_empty,
  output logic          txd,
  input  logic          rxd,
  input  logic          rx_read,
  output logic [7:0]    rx_data,
  output logic          rx_ready,
  input  logic          err_clr,
  output logic          parity_err,
  output logic          overrun_err,
  output logic          framing_err,
  output logic          break_det
);

  usart_cfg_t    cfg;
  logic          tx_load;
  logic          rx_done, rx_perr, rx_ferr, rx_brk, rx_brk_end, rx_false;
  logic [DW-1:0] rx_word;

  assign cfg = {char_len, parity_en, parity_odd, stop_sel, clk_mult};

  usart_tx u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (sclk_en),
    .cfg      (cfg),
    .wr       (tx_write),
    .wr_data  (tx_data),
    .brk      (send_break),
    .txd      (txd),
    .ready    (tx_ready),
    .empty    (tx_empty),
    .load_evt (tx_load)
  );

  usart_rx u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (sclk_en),
    .len       (char_len),
    .par_en    (parity_en),
    .par_odd   (parity_odd),
    .mult      (clk_mult),
    .rxd_in    (rxd),
    .done      (rx_done),
    .d_out     (rx_word),
    .perr      (rx_perr),
    .ferr      (rx_ferr),
    .brk_evt   (rx_brk),
    .brk_end   (rx_brk_end),
    .false_evt (rx_false)
  );

  usart_rxbuf u_rxbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .done    (rx_done),
    .d_in    (rx_word),
    .perr    (rx_perr),
    .ferr    (rx_ferr),
    .brk_evt (rx_brk),
    .brk_end (rx_brk_end),
    .rd      (rx_read),
    .clr     (err_clr),
    .data    (rx_data),
    .ready   (rx_ready),
    .perr_f  (parity_err),
    .ovr_f   (overrun_err),
    .ferr_f  (framing_err),
    .brk_f   (break_det)
  );

  // R10
  load_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> !tx_ready);

  // R6
  false_start_no_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_false |=> !rx_done);

endmodule

// File: tb/test_async_usart.sv
module test_async_usart;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk_en = 1'b1;
  logic       sclk_mode = 1'b0;
  logic [1:0] char_len = 2'd3;
  logic       parity_en = 1'b0;
  logic       parity_odd = 1'b0;
  logic [1:0] stop_sel = 2'd0;
  logic [1:0] clk_mult = 2'd1;
  logic       send_break = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_write = 1'b0;
  logic       tx_ready, tx_empty, txd;
  logic       rxd = 1'b1;
  logic       rx_read = 1'b0;
  logic [7:0] rx_data;
  logic       rx_ready;
  logic       err_clr = 1'b0;
  logic       parity_err, overrun_err, framing_err, break_det;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    cmp_on = 1'b0;
  string tx_tag = "R10";

  // behavioural transmit model: pending characters and per-tick line levels
  int hold[$];
  int lvl[$];
  bit m_idle = 1'b1;
  bit m_txq = 1'b1;
  bit m_had;

  async_usart i_async_usart (
    .clk(clk), .rst_n(rst_n), .sclk_en(sclk_en), .char_len(char_len),
    .parity_en(parity_en), .parity_odd(parity_odd), .stop_sel(stop_sel),
    .clk_mult(clk_mult), .send_break(send_break), .tx_data(tx_data),
    .tx_write(tx_write), .tx_ready(tx_ready), .tx_empty(tx_empty), .txd(txd),
    .rxd(rxd), .rx_read(rx_read), .rx_data(rx_data), .rx_ready(rx_ready),
    .err_clr(err_clr), .parity_err(parity_err), .overrun_err(overrun_err),
    .framing_err(framing_err), .break_det(break_det)
  );

  // 250 MHz: 4-unit period
  always #2 clk = ~clk;

  always @(negedge clk) sclk_en <= sclk_mode ? ~sclk_en : 1'b1;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int ticks_per_bit();
    return (clk_mult == 2'd0) ? 1 : (clk_mult == 2'd1) ? 16 : 64;
  endfunction

  function automatic void model_build(input int d);
    int m, n, ones, st_len, b;
    m = ticks_per_bit();
    n = 5 + int'(char_len);
    ones = 0;
    repeat (m) lvl.push_back(0);
    for (int i = 0; i < n; i++) begin
      b = (d >> i) & 1;
      ones += b;
      repeat (m) lvl.push_back(b);
    end
    if (parity_en) begin
      b = (ones % 2) ^ int'(parity_odd);
      repeat (m) lvl.push_back(b);
    end
    st_len = (stop_sel == 2'd0) ? m : (stop_sel == 2'd1) ? m + m / 2 : 2 * m;
    repeat (st_len) lvl.push_back(1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      hold.delete();
      lvl.delete();
      m_idle = 1'b1;
      m_txq = 1'b1;
    end else begin
      m_had = (hold.size() > 0);
      if (sclk_en) begin
        if (lvl.size() == 0) begin
          if (hold.size() > 0) begin
            model_build(hold.pop_front());
            m_txq = lvl.pop_front() != 0;
            m_idle = 1'b0;
          end else begin
            m_idle = 1'b1;
          end
        end else begin
          m_txq = lvl.pop_front() != 0;
        end
      end
      if (tx_write && !m_had) hold.push_back(int'(tx_data));
    end
  end

  // per-clock comparison against the model (R2, R3, R5, R10 depending on phase)
  always @(negedge clk) begin
    #1;
    if (rst_n && cmp_on) begin
      check({tx_tag, " txd"}, int'(txd), send_break ? 0 : int'(m_txq));
      check("R10 tx_ready", int'(tx_ready), (hold.size() == 0) ? 1 : 0);
      check("R10 tx_empty", int'(tx_empty), (hold.size() == 0 && m_idle) ? 1 : 0);
    end
  end

  task automatic cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic rx_frame(input int d, input int n, input bit pen, input bit podd,
                          input bit bad_par, input bit stopv, input int m);
    int ones;
    ones = 0;
    rxd = 1'b0;
    cyc(m);
    for (int i = 0; i < n; i++) begin
      rxd = ((d >> i) & 1) != 0;
      ones += (d >> i) & 1;
      cyc(m);
    end
    if (pen) begin
      rxd = (((ones % 2) ^ int'(podd) ^ int'(bad_par)) != 0);
      cyc(m);
    end
    rxd = stopv;
    cyc(m);
    rxd = 1'b1;
    cyc(m + 6);
  endtask

  task automatic do_read();
    rx_read = 1'b1;
    cyc(1);
    rx_read = 1'b0;
  endtask

  task automatic do_clear();
    err_clr = 1'b1;
    cyc(1);
    err_clr = 1'b0;
  endtask

  task automatic do_write(input int d);
    tx_data = d[7:0];
    tx_write = 1'b1;
    cyc(1);
    tx_write = 1'b0;
  endtask

  task automatic wait_tx_idle();
    cyc(2);
    while (!tx_empty) cyc(1);
    cyc(2);
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual expired expected completion");
    finish_run();
  end

  initial begin
    cyc(3);
    // R12: reset state
    check("R12 txd", int'(txd), 1);
    check("R12 tx_ready", int'(tx_ready), 1);
    check("R12 tx_empty", int'(tx_empty), 1);
    check("R12 rx_ready", int'(rx_ready), 0);
    check("R12 flags", int'({parity_err, overrun_err, framing_err, break_det}), 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    cyc(2);

    // R1 R2: 8N1 at x16
    rx_frame(8'hA5, 8, 0, 0, 0, 1, 16);
    check("R1 rx_data 8N1", int'(rx_data), 8'hA5);
    check("R2 rx_ready x16", int'(rx_ready), 1);
    check("R4 no parity err", int'(parity_err), 0);
    do_read();
    check("R11 read clears rx_ready", int'(rx_ready), 0);

    // R4: 7 data bits, even parity, x64
    char_len = 2'd2; parity_en = 1'b1; parity_odd = 1'b0; clk_mult = 2'd2;
    rx_frame(8'h35, 7, 1, 0, 0, 1, 64);
    check("R4 rx_data 7E", int'(rx_data), 8'h35);
    check("R4 good parity", int'(parity_err), 0);
    do_read();
    rx_frame(8'h35, 7, 1, 0, 1, 1, 64);
    check("R4 bad parity", int'(parity_err), 1);
    do_read();
    do_clear();
    check("R11 clear parity", int'(parity_err), 0);

    // R1: 5 data bits, odd parity, x1
    char_len = 2'd0; parity_odd = 1'b1; clk_mult = 2'd0;
    rx_frame(8'h16, 5, 1, 1, 0, 1, 1);
    check("R1 rx_data 5O x1", int'(rx_data), 8'h16);
    check("R4 odd parity ok", int'(parity_err), 0);
    do_read();

    // R8: low stop bit
    char_len = 2'd3; parity_en = 1'b0; parity_odd = 1'b0; clk_mult = 2'd1;
    rx_frame(8'h3C, 8, 0, 0, 0, 0, 16);
    check("R8 framing_err", int'(framing_err), 1);
    check("R8 no break", int'(break_det), 0);
    check("R8 rx_data", int'(rx_data), 8'h3C);
    do_read();
    cyc(2);
    check("R6 remnant of low stop not a char", int'(rx_ready), 0);
    do_clear();
    check("R11 clear framing", int'(framing_err), 0);

    // R9: overrun
    rx_frame(8'h11, 8, 0, 0, 0, 1, 16);
    rx_frame(8'h22, 8, 0, 0, 0, 1, 16);
    check("R9 overrun_err", int'(overrun_err), 1);
    check("R9 rx_data replaced", int'(rx_data), 8'h22);
    do_read();
    cyc(3);
    check("R11 overrun sticky", int'(overrun_err), 1);
    do_clear();
    check("R11 clear overrun", int'(overrun_err), 0);

    // R6: false start
    rxd = 1'b0;
    cyc(4);
    rxd = 1'b1;
    cyc(40);
    check("R6 glitch rejected", int'(rx_ready), 0);
    rx_frame(8'h6E, 8, 0, 0, 0, 1, 16);
    check("R6 next frame ok", int'(rx_data), 8'h6E);
    do_read();

    // R7: break
    rxd = 1'b0;
    cyc(200);
    check("R7 break_det", int'(break_det), 1);
    check("R7 framing with break", int'(framing_err), 1);
    check("R7 zero char", int'(rx_data), 0);
    cyc(100);
    check("R7 still held", int'(break_det), 1);
    rxd = 1'b1;
    cyc(6);
    check("R7 break cleared", int'(break_det), 0);
    do_read();
    do_clear();
    cyc(20);
    check("R7 no extra char", int'(rx_ready), 0);

    // R10: double-buffered transmit, write while full dropped
    tx_tag = "R10";
    do_write(8'h5A);
    cyc(3);
    do_write(8'h81);
    check("R10 holding full", int'(tx_ready), 0);
    check("R10 not empty", int'(tx_empty), 0);
    do_write(8'hFF);
    wait_tx_idle();
    check("R10 empty after", int'(tx_empty), 1);

    // R3: stop lengths, back-to-back
    tx_tag = "R3";
    char_len = 2'd2; parity_en = 1'b1; stop_sel = 2'd1; clk_mult = 2'd1;
    do_write(8'h2B);
    cyc(3);
    do_write(8'h44);
    wait_tx_idle();
    char_len = 2'd0; parity_odd = 1'b1; stop_sel = 2'd2; clk_mult = 2'd0;
    do_write(8'h13);
    cyc(3);
    do_write(8'h0C);
    wait_tx_idle();
    tx_tag = "R1";
    char_len = 2'd1; parity_en = 1'b0; parity_odd = 1'b0; stop_sel = 2'd0; clk_mult = 2'd2;
    do_write(8'h2A);
    wait_tx_idle();

    // R2: gated serial clock
    tx_tag = "R2";
    char_len = 2'd3; stop_sel = 2'd2; clk_mult = 2'd1;
    sclk_mode = 1'b1;
    do_write(8'hC3);
    wait_tx_idle();
    sclk_mode = 1'b0;
    cyc(2);

    // R5: send break, idle and mid-character
    tx_tag = "R5";
    send_break = 1'b1;
    for (int k = 0; k < 10; k++) begin
      cyc(1);
      check("R5 break idle", int'(txd), 0);
    end
    send_break = 1'b0;
    cyc(1);
    check("R5 released", int'(txd), 1);
    do_write(8'h0F);
    cyc(30);
    send_break = 1'b1;
    cyc(20);
    send_break = 1'b0;
    wait_tx_idle();

    cmp_on = 1'b0;
    cyc(2);
    finish_run();
  end

endmodule